// File: doc/BRIEF.md
# Byte-serial counter register interface

This block connects an 8-bit host bus to one 24-bit counter channel. It uses two addresses. Address bit 0 low selects the data port and bit 0 high selects the control port. A 24-bit quantity crosses the byte-wide data port as three bytes, least significant byte first. A two-bit byte pointer selects the byte for each access and steps on every data access. The counting logic sits outside this block. It supplies the live count on `count_in` and the flag byte on `flags_in`. This block holds the 24-bit preset register and the 8-bit filter clock prescaler, and drives both out to the counter.

A read sequence starts with command 11h on the control port, which sets the pointer to the low byte. Three data reads follow. The first read copies the whole count into a snapshot register and returns its low byte. The next two reads return the middle and high bytes of that same snapshot, so the three bytes always belong to one count value. A write sequence uses the same pointer and fills the preset register one byte at a time. The prescaler has no data path of its own. The host writes 11h, writes one byte to the data port (this lands in the preset low byte), then writes 19h. Command 19h copies the preset low byte into the prescaler.

The pointer is a three-state machine with states PTR_B0, PTR_B1 and PTR_B2. It has these transitions:
- ADVANCE: a data access moves B0→B1, B1→B2 and B2→B0.
- CLEAR: command 11h or 19h forces the pointer to B0 from any state.
- HOLD: any other cycle leaves the pointer where it is.

Top module: `bserial_ctr_if`

## Requirements
- R1: A synchronous active-high `rst` clears the pointer to PTR_B0 and clears `preset_q`, `psc_q`, `bus_rdata` and the snapshot to zero.
- R2: A control-port write (`bus_a0`=1) of 8'h11 sets the pointer to PTR_B0 and changes no other register.
- R3: A data read with the pointer at PTR_B0 captures all 24 bits of `count_in` into the snapshot and returns `count_in[7:0]`. Reads at PTR_B1 and PTR_B2 return snapshot bits [15:8] and [23:16], whatever `count_in` does in between.
- R4: A data-port write (`bus_a0`=0) stores `bus_wdata` into preset bits [8k+7:8k], where k is the pointer state (0, 1 or 2). The other preset bytes are unchanged.
- R5: Every data read or data write advances the pointer B0→B1→B2→B0. Reads and writes share the same pointer.
- R6: A control-port write of 8'h19 copies `preset_q[7:0]` into `psc_q` and sets the pointer to PTR_B0.
- R7: A control-port read returns `flags_in` on `bus_rdata` and does not move the pointer.
- R8: A control-port write of any value other than 8'h11 or 8'h19 leaves the pointer, `preset_q` and `psc_q` unchanged.
- R9: Read data appears on `bus_rdata` one clock after the read strobe. It holds that value until the next read.
- R10: If `bus_rd` and `bus_wr` are both high in one cycle, the cycle acts as a write only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_a0 | input | 1 | Port select: 0 selects data, 1 selects control |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 8 | Write data byte |
| bus_rdata | output | 8 | Registered read data byte |
| count_in | input | 24 | Live count from the counter |
| flags_in | input | 8 | Flag byte from the counter |
| preset_q | output | 24 | Preset register |
| psc_q | output | 8 | Filter clock prescaler register |

## Verification
The hardest case to reach is a torn read. The count must change between the first and the later bytes of a three-byte read, and the bench must show that the later bytes still come from the snapshot. The stimulus draws a new `count_in` before every bus operation, so every multi-byte read sees a moving count. A directed sequence also flips every count bit between the reads. Random mixes of command bytes, interleaved reads and writes, and simultaneous strobes move the shared pointer into unusual states before 11h or 19h resets it.

// File: rtl/bsc_pkg.sv
package bsc_pkg;
    localparam int BYTE_W = 8;
    localparam int NBYTES = 3;
    localparam int CNT_W  = BYTE_W * NBYTES;
    localparam int IDX_W  = 2;

    typedef enum logic [IDX_W-1:0] {
        PTR_B0 = 2'd0,
        PTR_B1 = 2'd1,
        PTR_B2 = 2'd2
    } ptr_state_t;

    typedef struct packed {
        logic data_rd;
        logic data_wr;
        logic ctrl_rd;
        logic ptr_clr;
        logic psc_ld;
    } bus_op_t;
endpackage

// File: rtl/bsc_cmd_decode.sv
module bsc_cmd_decode
    import bsc_pkg::*;
#(
    parameter logic [BYTE_W-1:0] CMD_PTR_CLR = 8'h11,
    parameter logic [BYTE_W-1:0] CMD_PSC_LD  = 8'h19
) (
    input  logic              bus_a0,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [BYTE_W-1:0] bus_wdata,
    output bus_op_t           op
);
    logic rd_eff;

    // a write strobe wins over a simultaneous read strobe
    assign rd_eff = bus_rd & ~bus_wr;

    always_comb begin
        op         = '0;
        op.data_rd = rd_eff & ~bus_a0;
        op.ctrl_rd = rd_eff &  bus_a0;
        op.data_wr = bus_wr & ~bus_a0;
        if (bus_wr && bus_a0) begin
            if (bus_wdata == CMD_PTR_CLR) begin
                op.ptr_clr = 1'b1;
            end else if (bus_wdata == CMD_PSC_LD) begin
                op.ptr_clr = 1'b1;
                op.psc_ld  = 1'b1;
            end
        end
    end
endmodule

// File: rtl/bsc_ptr_fsm.sv
module bsc_ptr_fsm
    import bsc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  bus_op_t    op,
    output ptr_state_t ptr
);
    ptr_state_t ptr_next;
    logic       step;

    assign step = op.data_rd | op.data_wr;

    always_ff @(posedge clk) begin
        if (rst) ptr <= PTR_B0;
        else     ptr <= ptr_next;
    end

    always_comb begin
        ptr_next = ptr;
        if (op.ptr_clr) begin
            ptr_next = PTR_B0;                 // CLEAR
        end else if (step) begin
            unique case (ptr)                  // ADVANCE
                PTR_B0:  ptr_next = PTR_B1;
                PTR_B1:  ptr_next = PTR_B2;
                PTR_B2:  ptr_next = PTR_B0;
                default: ptr_next = PTR_B0;
            endcase
        end
    end
endmodule

// File: rtl/bsc_preset_bank.sv
module bsc_preset_bank
    import bsc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  bus_op_t           op,
    input  ptr_state_t        ptr,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [CNT_W-1:0]  preset_q,
    output logic [BYTE_W-1:0] psc_q
);
    logic [NBYTES-1:0] byte_we;

    generate
        for (genvar k = 0; k < NBYTES; k++) begin : g_byte
            assign byte_we[k] = op.data_wr && (ptr == ptr_state_t'(k));

            always_ff @(posedge clk) begin
                if (rst)             preset_q[k*BYTE_W +: BYTE_W] <= '0;
                else if (byte_we[k]) preset_q[k*BYTE_W +: BYTE_W] <= bus_wdata;
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst)            psc_q <= '0;
        else if (op.psc_ld) psc_q <= preset_q[BYTE_W-1:0];
    end
endmodule

// File: rtl/bsc_read_latch.sv
module bsc_read_latch
    import bsc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  bus_op_t           op,
    input  ptr_state_t        ptr,
    input  logic [CNT_W-1:0]  count_in,
    input  logic [BYTE_W-1:0] flags_in,
    output logic [BYTE_W-1:0] bus_rdata
);
    logic [CNT_W-1:0]  snap;
    logic [BYTE_W-1:0] rd_byte;

    always_comb begin
        unique case (ptr)
            PTR_B0:  rd_byte = count_in[BYTE_W-1:0];
            PTR_B1:  rd_byte = snap[BYTE_W +: BYTE_W];
            PTR_B2:  rd_byte = snap[2*BYTE_W +: BYTE_W];
            default: rd_byte = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            snap      <= '0;
            bus_rdata <= '0;
        end else if (op.ctrl_rd) begin
            bus_rdata <= flags_in;
        end else if (op.data_rd) begin
            if (ptr == PTR_B0) snap <= count_in;
            bus_rdata <= rd_byte;
        end
    end
endmodule

// File: rtl/bserial_ctr_if.sv
module bserial_ctr_if
    import bsc_pkg::*;
#(
    parameter logic [BYTE_W-1:0] CMD_PTR_CLR = 8'h11,
    parameter logic [BYTE_W-1:0] CMD_PSC_LD  = 8'h19
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_a0,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    input  logic [CNT_W-1:0]  count_in,
    input  logic [BYTE_W-1:0] flags_in,
    output logic [CNT_W-1:0]  preset_q,
    output logic [BYTE_W-1:0] psc_q
);
    bus_op_t    op;
    ptr_state_t ptr_state;

    bsc_cmd_decode #(
        .CMD_PTR_CLR(CMD_PTR_CLR),
        .CMD_PSC_LD (CMD_PSC_LD)
    ) u_dec (
        .bus_a0   (bus_a0),
        .bus_rd   (bus_rd),
        .bus_wr   (bus_wr),
        .bus_wdata(bus_wdata),
        .op       (op)
    );

    bsc_ptr_fsm u_ptr (
        .clk(clk),
        .rst(rst),
        .op (op),
        .ptr(ptr_state)
    );

    bsc_preset_bank u_bank (
        .clk      (clk),
        .rst      (rst),
        .op       (op),
        .ptr      (ptr_state),
        .bus_wdata(bus_wdata),
        .preset_q (preset_q),
        .psc_q    (psc_q)
    );

    bsc_read_latch u_rd (
        .clk      (clk),
        .rst      (rst),
        .op       (op),
        .ptr      (ptr_state),
        .count_in (count_in),
        .flags_in (flags_in),
        .bus_rdata(bus_rdata)
    );
endmodule

// File: rtl/bsc_checker.sv
module bsc_checker
    import bsc_pkg::*;
#(
    parameter logic [BYTE_W-1:0] CMD_PTR_CLR = 8'h11,
    parameter logic [BYTE_W-1:0] CMD_PSC_LD  = 8'h19
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_a0,
    input logic              bus_rd,
    input logic              bus_wr,
    input logic [BYTE_W-1:0] bus_wdata,
    input logic [BYTE_W-1:0] bus_rdata,
    input logic [CNT_W-1:0]  count_in,
    input logic [BYTE_W-1:0] flags_in,
    input logic [CNT_W-1:0]  preset_q,
    input logic [BYTE_W-1:0] psc_q,
    input logic [IDX_W-1:0]  ptr
);
    logic ctl_wr, is_clr, is_ld, rd_only;
    assign ctl_wr  = bus_wr && bus_a0;
    assign is_clr  = ctl_wr && (bus_wdata == CMD_PTR_CLR);
    assign is_ld   = ctl_wr && (bus_wdata == CMD_PSC_LD);
    assign rd_only = bus_rd && !bus_wr;

    assert_rst_clear_R1: assert property (@(posedge clk)
        rst |=> (ptr == 2'd0 && preset_q == '0 && psc_q == '0 && bus_rdata == '0));

    assert_ptr_clear_R2: assert property (@(posedge clk) disable iff (rst)
        is_clr |=> (ptr == 2'd0 && $stable(preset_q) && $stable(psc_q)));

    assert_low_byte_live_R3: assert property (@(posedge clk) disable iff (rst)
        (rd_only && !bus_a0 && ptr == 2'd0) |=> (bus_rdata == $past(count_in[7:0])));

    assert_preset_hold_R4: assert property (@(posedge clk) disable iff (rst)
        !(bus_wr && !bus_a0) |=> $stable(preset_q));

    assert_ptr_legal_R5: assert property (@(posedge clk) disable iff (rst)
        ptr != 2'd3);

    assert_psc_load_R6: assert property (@(posedge clk) disable iff (rst)
        is_ld |=> (psc_q == $past(preset_q[7:0]) && ptr == 2'd0));

    assert_flag_read_R7: assert property (@(posedge clk) disable iff (rst)
        (rd_only && bus_a0) |=> (bus_rdata == $past(flags_in) && $stable(ptr)));

    assert_psc_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !is_ld |=> $stable(psc_q));

    assert_rdata_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !rd_only |=> $stable(bus_rdata));
endmodule

bind bserial_ctr_if bsc_checker #(
    .CMD_PTR_CLR(CMD_PTR_CLR),
    .CMD_PSC_LD (CMD_PSC_LD)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .bus_a0   (bus_a0),
    .bus_rd   (bus_rd),
    .bus_wr   (bus_wr),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .count_in (count_in),
    .flags_in (flags_in),
    .preset_q (preset_q),
    .psc_q    (psc_q),
    .ptr      (ptr_state)
);

// File: tb/tb_bserial_ctr_if.sv
`timescale 1ns/1ps
module tb_bserial_ctr_if;
    logic        clk = 1'b0;
    logic        rst;
    logic        bus_a0, bus_rd, bus_wr;
    logic [7:0]  bus_wdata, bus_rdata, flags_in, psc_q;
    logic [23:0] count_in, preset_q;

    int tests = 0;
    int fails = 0;

    // reference model
    int          m_ptr;
    logic [23:0] m_preset, m_snap;
    logic [7:0]  m_psc, m_rdata;

    always #2 clk = ~clk;

    bserial_ctr_if dut (
        .clk(clk), .rst(rst), .bus_a0(bus_a0), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .count_in(count_in),
        .flags_in(flags_in), .preset_q(preset_q), .psc_q(psc_q)
    );

    task automatic chk(input string tag, input logic [23:0] act, input logic [23:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic void model(input logic rd, input logic wr, input logic a0,
                                  input logic [7:0] wd);
        if (wr) begin
            if (!a0) begin
                m_preset[m_ptr*8 +: 8] = wd;
                m_ptr = (m_ptr + 1) % 3;
            end else if (wd == 8'h11) begin
                m_ptr = 0;
            end else if (wd == 8'h19) begin
                m_psc = m_preset[7:0];
                m_ptr = 0;
            end
        end else if (rd) begin
            if (a0) begin
                m_rdata = flags_in;
            end else begin
                if (m_ptr == 0) m_snap = count_in;
                m_rdata = m_snap[m_ptr*8 +: 8];
                m_ptr = (m_ptr + 1) % 3;
            end
        end
    endfunction

    task automatic op(input string tag, input logic rd, input logic wr, input logic a0,
                      input logic [7:0] wd);
        @(negedge clk);
        bus_rd = rd; bus_wr = wr; bus_a0 = a0; bus_wdata = wd;
        model(rd, wr, a0, wd);
        @(negedge clk);
        bus_rd = 1'b0; bus_wr = 1'b0;
        chk({tag, " rdata"},  {16'h0, bus_rdata}, {16'h0, m_rdata});
        chk({tag, " preset"}, preset_q, m_preset);
        chk({tag, " psc"},    {16'h0, psc_q}, {16'h0, m_psc});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_0042));
        rst = 1'b1; bus_a0 = 0; bus_rd = 0; bus_wr = 0; bus_wdata = 0;
        count_in = 24'h123456; flags_in = 8'h5a;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        m_ptr = 0; m_preset = 0; m_snap = 0; m_psc = 0; m_rdata = 0;
        // R1: reset values
        chk("R1 rdata",  {16'h0, bus_rdata}, 24'h0);
        chk("R1 preset", preset_q, 24'h0);
        chk("R1 psc",    {16'h0, psc_q}, 24'h0);
        // R1: pointer at low byte after reset
        op("R1 first read", 1, 0, 0, 8'h00);

        // R3: coherent snapshot while count changes
        op("R2 clear", 0, 1, 1, 8'h11);
        count_in = 24'hA1B2C3;
        op("R3 byte0", 1, 0, 0, 8'h00);
        count_in = ~count_in;
        op("R3 byte1", 1, 0, 0, 8'h00);
        count_in = 24'h000000;
        op("R3 byte2", 1, 0, 0, 8'h00);
        count_in = 24'hFEDCBA;
        op("R5 wrap relatch", 1, 0, 0, 8'h00);

        // R4: preset fill
        op("R2 clear", 0, 1, 1, 8'h11);
        op("R4 wr0", 0, 1, 0, 8'h11);
        op("R4 wr1", 0, 1, 0, 8'h22);
        op("R4 wr2", 0, 1, 0, 8'h33);
        op("R5 wr wrap", 0, 1, 0, 8'h44);

        // R6: prescaler load sequence
        op("R2 clear", 0, 1, 1, 8'h11);
        op("R6 wr low", 0, 1, 0, 8'h9c);
        op("R6 load", 0, 1, 1, 8'h19);
        op("R6 ptr at b0", 0, 1, 0, 8'h77);

        // R8: ignored command does not touch the pointer
        op("R8 wr", 0, 1, 0, 8'h01);
        op("R8 other cmd", 0, 1, 1, 8'h12);
        op("R8 other cmd", 0, 1, 1, 8'h18);
        op("R8 next byte", 0, 1, 0, 8'h02);

        // R7: flag read, pointer still
        flags_in = 8'h3c;
        op("R7 flags", 1, 0, 1, 8'h00);
        op("R7 ptr unchanged", 0, 1, 0, 8'h03);

        // R10: both strobes -> write only
        op("R10 both", 1, 1, 0, 8'hee);
        op("R10 both ctrl", 1, 1, 1, 8'h11);

        // R9: hold with idle cycles
        op("R9 read", 1, 0, 0, 8'h00);
        count_in = 24'h555555; flags_in = 8'haa;
        op("R9 idle hold", 0, 0, 0, 8'h00);
        op("R9 idle hold", 0, 0, 1, 8'h00);

        // random mix
        for (int i = 0; i < 800; i++) begin
            int sel = $urandom_range(0, 9);
            logic [7:0] d = 8'($urandom);
            count_in = 24'($urandom);
            flags_in = 8'($urandom);
            case (sel)
                0, 1, 2: op("R3 R5 rand rd",  1, 0, 0, d);
                3, 4:    op("R4 R5 rand wr",  0, 1, 0, d);
                5:       op("R2 rand clr",    0, 1, 1, 8'h11);
                6:       op("R6 rand ld",     0, 1, 1, 8'h19);
                7:       op("R8 rand cmd",    0, 1, 1, d);
                8:       op("R7 rand flags",  1, 0, 1, d);
                default: op("R10 rand both",  1, 1, d[0], d);
            endcase
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule